// File: doc/BRIEF.md
# ISA 8-bit memory cycle sequencer

This block is a bus master that runs single 8-bit memory reads and writes on an ISA-style expansion bus. A host raises a one-clock request with an address, a direction bit and a write byte. While the cycle runs, the block shows busy. It returns the read byte together with a single-clock done pulse.

On the bus side, the block drives the latched upper address (LA) and the unlatched system address (SA), and pulses BALE. It then asserts the active-low read or write strobe, enables the data buffer and steers the read direction. It samples IOCHRDY through a synchronizer, so a slow target can stretch the strobe.

Every phase length is a parameter given in nanoseconds. Each one is turned into whole clock counts, rounded up, using a clock-period parameter.

Top module: `isa8_mem_seq`

## Requirements
- R1: While reset is held and just after it, both strobes are high, BALE is low, and all output enables (la_oe_o, sa_oe_o, wd_oe_o, dbuf_en_o, rd_dir_o) are low. busy_o and done_o are also low.
- R2: A request is taken only while idle, and the cycle after acceptance drives LA. A request raised while busy is ignored. done_o is high for exactly one clock, C_REC clocks after the strobe goes inactive: 2 clocks after a write and 1 after a read at the default 25 ns clock. busy_o is low in that clock.
- R3: LA is driven ceil(15 ns) clocks before SA. While the strobe is active, la_o carries address bits 23..17 and sa_o carries address bits 19..0.
- R4: BALE rises in the clock where SA is first driven. It stays high for the largest of ceil(35), ceil(45) and ceil(60) minus the LA-to-SA count, in clocks (2 at the defaults).
- R5: The strobe starts after BALE falls, by the largest of ceil(140), ceil(160) minus the BALE count, ceil(40), and ceil(170) minus the LA and BALE counts, in clocks (6 at the defaults).
- R6: A write asserts only memw_n_o and a read only memr_n_o, never both. When IOCHRDY stays high, the strobe lasts ceil(500 ns) clocks for a write and ceil(550 ns) for a read (20 and 22 at the defaults).
- R7: If IOCHRDY is held low from BALE and rises W clocks after the strobe starts, the strobe lasts max(W+3+H, P) clocks. P is the R6 width. H is ceil(110 ns) for a write and ceil(160 ns) for a read. The 3 covers a 2-flop synchronizer and the hand-over clock.
- R8: On a write, wd_o carries the byte from the LA clock onward. wd_oe_o and dbuf_en_o stay on for ceil(50 ns) clocks after the strobe ends. dbuf_en_o is high only during the strobe and this hold, and rd_dir_o stays low.
- R9: On a read, rdata_o takes rd_i at the clock edge that ends the strobe. rd_dir_o is high from the LA clock until the strobe ends. dbuf_en_o is high exactly during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a cycle (taken when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Memory address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Last captured read byte |
| la_o | output | 7 | Latched upper address |
| la_oe_o | output | 1 | LA drive enable |
| sa_o | output | 20 | System address |
| sa_oe_o | output | 1 | SA drive enable |
| bale_o | output | 1 | Address latch enable |
| memr_n_o | output | 1 | Read strobe, active low |
| memw_n_o | output | 1 | Write strobe, active low |
| dbuf_en_o | output | 1 | Data buffer enable |
| rd_dir_o | output | 1 | Buffer direction toward host (read) |
| wd_o | output | 8 | Write data toward the bus |
| wd_oe_o | output | 1 | Write data drive enable |
| rd_i | input | 8 | Read data from the bus |
| iochrdy_i | input | 1 | Target ready, low stretches the strobe |

## Verification
The assertions assume that IOCHRDY, when a target wants to stretch the strobe, is already low before the two-clock ready sample point. They also assume that a request never arrives during internal reset. The bench's target model pulls IOCHRDY low as soon as BALE is seen, and releases it a chosen number of clocks after the strobe starts. It offers requests only after the reset synchronizer has let go. Read data is made valid only while the strobe is active, so a capture one clock late reads the inverted byte.

// File: rtl/isa8_pkg.sv
`timescale 1ns/1ps
package isa8_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LA,
    ST_BALE,
    ST_GAP,
    ST_CMD,
    ST_WAIT,
    ST_HOLD,
    ST_RUN,
    ST_REC
  } seq_st_e;

  function automatic int cdiv(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/isa8_rst_sync.sv
`timescale 1ns/1ps
module isa8_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_o = sh_q[1];
endmodule

// File: rtl/isa8_sync.sv
`timescale 1ns/1ps
module isa8_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= RST_VAL;
        else        sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/isa8_down_cnt.sv
`timescale 1ns/1ps
module isa8_down_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i)               cnt_d = val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/isa8_mem_seq.sv
`timescale 1ns/1ps
module isa8_mem_seq
  import isa8_pkg::*;
#(
  parameter int CLK_NS      = 25,
  parameter int ADDR_W      = 24,
  parameter int LA_LSB      = 17,
  parameter int SA_W        = 20,
  parameter int T_LA_SA     = 15,
  parameter int T_BALE_W    = 35,
  parameter int T_SA_BALE   = 45,
  parameter int T_LA_BALE   = 60,
  parameter int T_LA_HOLD   = 40,
  parameter int T_BALE_CMD  = 140,
  parameter int T_SA_CMD    = 160,
  parameter int T_DIR_CMD   = 170,
  parameter int T_PW_WR     = 500,
  parameter int T_PW_RD     = 550,
  parameter int T_RH_WR     = 110,
  parameter int T_RH_RD     = 160,
  parameter int T_WD_HOLD   = 50,
  parameter int RDY_SAMPLE  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [7:0]               wdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [7:0]               rdata_o,
  output logic [ADDR_W-LA_LSB-1:0] la_o,
  output logic                     la_oe_o,
  output logic [SA_W-1:0]          sa_o,
  output logic                     sa_oe_o,
  output logic                     bale_o,
  output logic                     memr_n_o,
  output logic                     memw_n_o,
  output logic                     dbuf_en_o,
  output logic                     rd_dir_o,
  output logic [7:0]               wd_o,
  output logic                     wd_oe_o,
  input  logic [7:0]               rd_i,
  input  logic                     iochrdy_i
);

  localparam int LA_W   = ADDR_W - LA_LSB;
  localparam int C_LASA = imax(1, cdiv(T_LA_SA, CLK_NS));
  localparam int C_BALE = imax(1, imax(imax(cdiv(T_BALE_W, CLK_NS), cdiv(T_SA_BALE, CLK_NS)),
                                       cdiv(T_LA_BALE, CLK_NS) - C_LASA));
  localparam int C_GAP  = imax(1, imax(imax(cdiv(T_BALE_CMD, CLK_NS), cdiv(T_SA_CMD, CLK_NS) - C_BALE),
                                       imax(cdiv(T_LA_HOLD, CLK_NS),
                                            cdiv(T_DIR_CMD, CLK_NS) - C_LASA - C_BALE)));
  localparam int C_RDY  = imax(2, RDY_SAMPLE);
  localparam int C_PW_W = imax(C_RDY + 1, cdiv(T_PW_WR, CLK_NS));
  localparam int C_PW_R = imax(C_RDY + 1, cdiv(T_PW_RD, CLK_NS));
  localparam int C_RH_W = imax(1, cdiv(T_RH_WR, CLK_NS));
  localparam int C_RH_R = imax(1, cdiv(T_RH_RD, CLK_NS));
  localparam int C_RC_W = imax(1, cdiv(T_WD_HOLD, CLK_NS));
  localparam int C_RC_R = 1;
  localparam int C_MAX  = imax(imax(imax(C_PW_W, C_PW_R), imax(C_GAP, C_BALE)),
                               imax(imax(C_RH_W, C_RH_R), imax(C_RC_W, C_LASA)));
  localparam int CNT_W  = $clog2(C_MAX + 1);

  // Reset release and ready synchronization
  logic rst_q_n;
  logic rdy_s;

  isa8_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  isa8_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   (iochrdy_i),
    .q_o   (rdy_s)
  );

  // Phase timer and command width timer
  logic             ph_ld, pw_ld, ph_done, pw_done;
  logic [CNT_W-1:0] ph_val, pw_val;

  isa8_down_cnt #(.W(CNT_W)) u_ph (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ld_i   (ph_ld),
    .val_i  (ph_val),
    .zero_o (ph_done)
  );

  isa8_down_cnt #(.W(CNT_W)) u_pw (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ld_i   (pw_ld),
    .val_i  (pw_val),
    .zero_o (pw_done)
  );

  // Request registers
  seq_st_e           st_q, st_d;
  logic              take;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wd_q;
  logic [7:0]        rdata_q;
  logic              done_q, done_d;
  logic              cap;

  assign take = req_i && (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (take) begin
      wr_q   <= wr_i;
      addr_q <= addr_i;
      wd_q   <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)            rdata_q <= '0;
    else if (cap && !wr_q)   rdata_q <= rd_i;
  end

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    ph_ld  = 1'b0;
    ph_val = '0;
    pw_ld  = 1'b0;
    pw_val = '0;
    cap    = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d = ST_LA;  ph_ld = 1'b1; ph_val = CNT_W'(C_LASA - 1);
      end
      ST_LA: if (ph_done) begin
        st_d = ST_BALE; ph_ld = 1'b1; ph_val = CNT_W'(C_BALE - 1);
      end
      ST_BALE: if (ph_done) begin
        st_d = ST_GAP; ph_ld = 1'b1; ph_val = CNT_W'(C_GAP - 1);
      end
      ST_GAP: if (ph_done) begin
        st_d   = ST_CMD;
        ph_ld  = 1'b1; ph_val = CNT_W'(C_RDY - 1);
        pw_ld  = 1'b1; pw_val = wr_q ? CNT_W'(C_PW_W - 1) : CNT_W'(C_PW_R - 1);
      end
      ST_CMD: if (ph_done) begin
        st_d = rdy_s ? ST_RUN : ST_WAIT;
      end
      ST_WAIT: if (rdy_s) begin
        st_d  = ST_HOLD;
        ph_ld = 1'b1; ph_val = wr_q ? CNT_W'(C_RH_W - 1) : CNT_W'(C_RH_R - 1);
      end
      ST_HOLD: if (ph_done && pw_done) begin
        st_d  = ST_REC; cap = 1'b1;
        ph_ld = 1'b1; ph_val = wr_q ? CNT_W'(C_RC_W - 1) : CNT_W'(C_RC_R - 1);
      end
      ST_RUN: if (pw_done) begin
        st_d  = ST_REC; cap = 1'b1;
        ph_ld = 1'b1; ph_val = wr_q ? CNT_W'(C_RC_W - 1) : CNT_W'(C_RC_R - 1);
      end
      ST_REC: if (ph_done) begin
        st_d = ST_IDLE; done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  // Output decode from state registers
  logic cmd_act, pre_cmd;

  assign cmd_act   = st_q inside {ST_CMD, ST_WAIT, ST_HOLD, ST_RUN};
  assign pre_cmd   = st_q inside {ST_LA, ST_BALE, ST_GAP};
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign la_oe_o   = (st_q != ST_IDLE);
  assign sa_oe_o   = (st_q != ST_IDLE) && (st_q != ST_LA);
  assign la_o      = la_oe_o ? addr_q[ADDR_W-1:LA_LSB] : '0;
  assign sa_o      = sa_oe_o ? addr_q[SA_W-1:0] : '0;
  assign bale_o    = (st_q == ST_BALE);
  assign memr_n_o  = !(cmd_act && !wr_q);
  assign memw_n_o  = !(cmd_act && wr_q);
  assign dbuf_en_o = cmd_act || ((st_q == ST_REC) && wr_q);
  assign rd_dir_o  = !wr_q && (pre_cmd || cmd_act);
  assign wd_oe_o   = wr_q && (st_q != ST_IDLE);
  assign wd_o      = wd_oe_o ? wd_q : '0;

  // Checker: strobe length since the last BALE
  logic        strb_on;
  logic [15:0] chk_len_q;

  assign strb_on = !memr_n_o || !memw_n_o;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)                              chk_len_q <= '0;
    else if (bale_o)                           chk_len_q <= '0;
    else if (strb_on && chk_len_q != 16'hFFFF) chk_len_q <= chk_len_q + 16'd1;
  end

  // R6
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(!memr_n_o && !memw_n_o));

  // R6
  pw_min_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(strb_on) |-> (chk_len_q >= (wr_q ? 16'(C_PW_W) : 16'(C_PW_R))));

  // R5
  bale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    bale_o |-> (memr_n_o && memw_n_o));

  // R4
  bale_addr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    bale_o |-> (sa_oe_o && la_oe_o));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |=> !done_o);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(busy_o) |-> $past(req_i));

  // R8
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !memw_n_o |-> (wd_oe_o && dbuf_en_o && !rd_dir_o));

  // R9
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !memr_n_o |-> (rd_dir_o && dbuf_en_o && !wd_oe_o));

endmodule

// File: tb/test_isa8_mem_seq.sv
`timescale 1ns/1ps
module test_isa8_mem_seq;

  localparam int CLK_PERIOD = 25;
  localparam int WDOG       = 200000;

  function automatic int cd(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_LASA = mx(1, cd(15));
  localparam int B_BALE = mx(mx(cd(35), cd(45)), cd(60) - B_LASA);
  localparam int B_GAP  = mx(mx(cd(140), cd(160) - B_BALE), mx(cd(40), cd(170) - B_LASA - B_BALE));
  localparam int B_PW_W = cd(500);
  localparam int B_PW_R = cd(550);
  localparam int B_RH_W = cd(110);
  localparam int B_RH_R = cd(160);
  localparam int B_RC_W = cd(50);
  localparam int B_RC_R = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        busy_o, done_o, la_oe_o, sa_oe_o, bale_o;
  logic        memr_n_o, memw_n_o, dbuf_en_o, rd_dir_o, wd_oe_o;
  logic [7:0]  rdata_o, wd_o;
  logic [6:0]  la_o;
  logic [19:0] sa_o;
  logic [7:0]  rd_i = '0;
  logic        iochrdy_i = 1'b1;

  isa8_mem_seq i_isa8_mem_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .la_o(la_o), .la_oe_o(la_oe_o), .sa_o(sa_o), .sa_oe_o(sa_oe_o),
    .bale_o(bale_o), .memr_n_o(memr_n_o), .memw_n_o(memw_n_o),
    .dbuf_en_o(dbuf_en_o), .rd_dir_o(rd_dir_o), .wd_o(wd_o), .wd_oe_o(wd_oe_o),
    .rd_i(rd_i), .iochrdy_i(iochrdy_i)
  );

  always #(CLK_PERIOD/2.0) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Stimulus-side expectations (written only by the main flow)
  logic [6:0]  exp_la = '0;
  logic [19:0] exp_sa = '0;
  logic [7:0]  exp_wd = '0;
  logic        stretch_en = 1'b0;
  int          wait_w = 0;

  // Monitor and target model (written only here)
  int t_la, t_sa, t_br, t_bf, t_cs, t_ce, t_wdoff, t_done;
  int n_dir = 0, n_dbuf = 0, n_done = 0, n_both = 0, n_bad = 0;
  logic saw_r, saw_w;
  logic p_la = 0, p_sa = 0, p_bale = 0, p_act = 0, p_wd = 0;

  always @(negedge clk) begin
    logic act;
    act = !memr_n_o || !memw_n_o;
    if (la_oe_o && !p_la)   t_la = cyc;
    if (sa_oe_o && !p_sa)   t_sa = cyc;
    if (bale_o && !p_bale)  t_br = cyc;
    if (!bale_o && p_bale)  t_bf = cyc;
    if (act && !p_act) begin
      t_cs = cyc; saw_r = !memr_n_o; saw_w = !memw_n_o;
    end
    if (!act && p_act)      t_ce = cyc;
    if (!wd_oe_o && p_wd)   t_wdoff = cyc;
    if (done_o) begin t_done = cyc; n_done++; end
    if (rd_dir_o)  n_dir++;
    if (dbuf_en_o) n_dbuf++;
    if (!memr_n_o && !memw_n_o) n_both++;
    if (act && (la_o != exp_la || sa_o != exp_sa)) n_bad++;
    if (!memw_n_o && wd_o != exp_wd) n_bad++;
    if (!rst_n) iochrdy_i = 1'b1;
    else begin
      if (stretch_en && bale_o) iochrdy_i = 1'b0;
      if (stretch_en && act && (cyc - t_cs) == wait_w) iochrdy_i = 1'b1;
    end
    rd_i = act ? exp_wd : ~exp_wd;
    p_la = la_oe_o; p_sa = sa_oe_o; p_bale = bale_o; p_act = act; p_wd = wd_oe_o;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input bit wr, input bit st, input int w);
    int pw, rh;
    pw = wr ? B_PW_W : B_PW_R;
    rh = wr ? B_RH_W : B_RH_R;
    if (!st) return pw;
    return mx(w + 3 + rh, pw);
  endfunction

  task automatic run_txn(input bit wr, input logic [23:0] addr, input logic [7:0] data,
                         input bit st, input int w, input bit inject);
    int t_req, b_dir, b_dbuf, b_done, b_both, b_bad, len, la_mark;
    exp_la = addr[23:17]; exp_sa = addr[19:0]; exp_wd = data;
    stretch_en = st; wait_w = w;
    @(negedge clk);
    b_dir = n_dir; b_dbuf = n_dbuf; b_done = n_done; b_both = n_both; b_bad = n_bad;
    req_i = 1'b1; wr_i = wr; addr_i = addr; wdata_i = data; t_req = cyc;
    @(negedge clk);
    req_i = 1'b0; wr_i = ~wr; addr_i = ~addr; wdata_i = ~data;
    if (inject) begin
      repeat (3) @(negedge clk);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    len = exp_len(wr, st, w);
    chk(t_la - t_req == 1, "R2 accept latency", t_la - t_req, 1);
    chk(t_sa - t_la == B_LASA, "R3 LA to SA", t_sa - t_la, B_LASA);
    chk(n_bad == b_bad, "R3 address/data on bus", n_bad - b_bad, 0);
    chk(t_br == t_sa, "R4 BALE rise with SA", t_br, t_sa);
    chk(t_bf - t_br == B_BALE, "R4 BALE width", t_bf - t_br, B_BALE);
    chk(t_cs - t_bf == B_GAP, "R5 BALE fall to strobe", t_cs - t_bf, B_GAP);
    chk(saw_w == wr && saw_r == !wr && n_both == b_both, "R6 strobe select",
        {30'd0, saw_w, saw_r}, wr ? 2 : 1);
    chk(t_ce - t_cs == len, st ? "R7 stretched strobe width" : "R6 strobe width",
        t_ce - t_cs, len);
    chk(t_done - t_ce == (wr ? B_RC_W : B_RC_R), "R2 done timing", t_done - t_ce,
        wr ? B_RC_W : B_RC_R);
    chk(n_done - b_done == 1 && !busy_o, "R2 single done pulse", n_done - b_done, 1);
    if (wr) begin
      chk(t_wdoff - t_ce == B_RC_W, "R8 write data hold", t_wdoff - t_ce, B_RC_W);
      chk(n_dbuf - b_dbuf == len + B_RC_W, "R8 buffer enable span", n_dbuf - b_dbuf, len + B_RC_W);
      chk(n_dir == b_dir, "R8 no read direction on write", n_dir - b_dir, 0);
    end else begin
      chk(rdata_o == data, "R9 read capture", rdata_o, data);
      chk(n_dir - b_dir == t_ce - t_la, "R9 direction span", n_dir - b_dir, t_ce - t_la);
      chk(n_dbuf - b_dbuf == len, "R9 buffer enable span", n_dbuf - b_dbuf, len);
    end
    if (inject) begin
      la_mark = t_la;
      repeat (6) @(negedge clk);
      chk(t_la == la_mark && !busy_o, "R2 request while busy ignored", t_la, la_mark);
    end
    stretch_en = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    bit wd_hit;
    seed = $urandom(32'h1A5E_8B17);
    wd_hit = 1'b0;
    fork
      begin
        repeat (4) @(negedge clk);
        // R1: outputs while reset held
        chk(memr_n_o && memw_n_o && !bale_o, "R1 strobes in reset", {memr_n_o, memw_n_o, bale_o}, 6);
        chk(!la_oe_o && !sa_oe_o && !wd_oe_o && !dbuf_en_o && !rd_dir_o, "R1 enables in reset",
            {la_oe_o, sa_oe_o, wd_oe_o, dbuf_en_o, rd_dir_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy_o && !done_o && memr_n_o && memw_n_o && !la_oe_o, "R1 state after reset",
            {busy_o, done_o, memr_n_o, memw_n_o, la_oe_o}, 6);
        // Directed corners
        run_txn(1'b1, 24'hA5_1234, 8'h3C, 1'b0, 0, 1'b0);
        run_txn(1'b0, 24'h5A_4321, 8'hC3, 1'b0, 0, 1'b0);
        run_txn(1'b0, 24'h12_0F0F, 8'h81, 1'b1, 0, 1'b0);
        run_txn(1'b1, 24'hFE_DCBA, 8'h7E, 1'b1, B_PW_W - 3 - B_RH_W, 1'b0);
        run_txn(1'b1, 24'h01_0001, 8'h01, 1'b1, B_PW_W - 2 - B_RH_W, 1'b0);
        run_txn(1'b0, 24'h80_8000, 8'hF0, 1'b1, B_PW_R - 3 - B_RH_R, 1'b0);
        run_txn(1'b0, 24'h7F_FFFF, 8'h0F, 1'b1, B_PW_R - 2 - B_RH_R, 1'b0);
        run_txn(1'b1, 24'h33_3333, 8'h99, 1'b1, 40, 1'b0);
        run_txn(1'b0, 24'hC0_FFEE, 8'h66, 1'b0, 0, 1'b1);
        // Constrained random
        for (int i = 0; i < 24; i++) begin
          run_txn(1'($urandom % 2), 24'($urandom), 8'($urandom),
                  1'($urandom % 2), int'($urandom % 30), 1'($urandom % 4 == 0));
        end
      end
      begin
        repeat (WDOG) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) chk(1'b0, "watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule